// File: doc/BRIEF.md
# Lockable Memory Bank Configuration Registers

This block is a small register file that holds the timing and width settings of four external memory banks. Software reaches it through a simple register bus with a byte address, a write strobe, a read strobe and 32-bit data. Each bank owns one 32-bit configuration word. All four words share one field layout: wait-pin enable, write data drive delay, bus width, access duration, bus release time, strobe assert delays and early-release times. The block drives all four words, and a decoded narrow-bank flag per bank, to the memory strobe generator.

Configuration can be frozen. Any write to the lock location freezes the four words until the next reset, and the written data does not matter. A sticky status word shows which configuration words have taken at least one accepted write. Unmapped or misaligned offsets read as zero, and writes to them change nothing.

Top module: `bank_cfg_regs`

## Requirements
- R1: After reset, every configuration word reads back and is exported as the parameter default with bit 31 cleared. The status word reads 0 and the block is unlocked.
- R2: While the block is unlocked, a write to byte offset 4*i (i = 0..3) replaces configuration word i and leaves the other words unchanged.
- R3: Bit 31 of every configuration word always reads 0, and the value written to bit 31 is discarded.
- R4: Any write to offset 0x10 sets the lock, whatever its data. A read of offset 0x10 returns 0.
- R5: While the lock is set, writes to offsets 0x00 to 0x0C are discarded and the configuration words keep their values.
- R6: Only reset clears the lock. Further writes to 0x10, or to any other offset, leave it set.
- R7: The status word at offset 0x14 holds bit i = 1 once configuration word i has taken an accepted write. Bits 31:4 read 0. Writes to 0x14 are ignored, and writes rejected by the lock set no status bit.
- R8: Any offset other than 0x00, 0x04, 0x08, 0x0C, 0x10 and 0x14 is unmapped, including offsets with address bits 1:0 not zero. An unmapped read returns 0 and an unmapped write has no effect.
- R9: `cfg_word_o[32*i +: 32]` always equals configuration word i. `bank_narrow_o[i]` equals bit 4 of that word (1 = 8-bit bank, 0 = 16-bit bank).
- R10: `bus_rdata` loads the addressed value on the clock edge where `bus_rd` is high. When `bus_rd` is low it holds its value. A read in the same cycle as a write to the same offset returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 8 | Byte offset from block base |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| cfg_word_o | output | 128 | Four configuration words, bank i at bits 32*i+31:32*i |
| bank_narrow_o | output | 4 | Per-bank 8-bit width flag |

## Verification
On every cycle the assertions check the following:
- a set lock stays set;
- a locked word does not change;
- bit 31 stays clear;
- status bits are sticky and rise after an accepted write;
- read data holds between reads;
- unmapped reads give zero.

The bench scenarios alone show the values that must appear:
- which word a given offset hits;
- that lock data of zero still locks;
- that rejected writes leave status bits untouched;
- the read-before-write ordering of a same-cycle access;
- that reset reopens a locked block.

// File: rtl/bank_cfg_pkg.sv
package bank_cfg_pkg;
  localparam int CFG_W     = 32;
  localparam int RSVD_BIT  = 31;
  localparam int WIDTH_BIT = 4;
  localparam logic [CFG_W-1:0] CFG_MASK = {1'b0, {(CFG_W-1){1'b1}}};

  // Clear the reserved bit before storing a word.
  function automatic logic [CFG_W-1:0] cfg_sanitize(input logic [CFG_W-1:0] w);
    return w & CFG_MASK;
  endfunction

  // Bus width field: 1 = 8-bit bank, 0 = 16-bit bank.
  function automatic logic cfg_is_narrow(input logic [CFG_W-1:0] w);
    return w[WIDTH_BIT];
  endfunction
endpackage

// File: rtl/bank_cfg_decode.sv
module bank_cfg_decode #(
  parameter int ADDR_W = 8,
  parameter int NBANK  = 4
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [NBANK-1:0]  cfg_sel,
  output logic              lock_hit,
  output logic              stat_hit
);
  localparam int IDX_W = ADDR_W - 2;
  localparam int LOCK_IDX = NBANK;
  localparam int STAT_IDX = NBANK + 1;

  logic [IDX_W-1:0] word_idx;
  logic             aligned;

  assign word_idx = addr[ADDR_W-1:2];
  assign aligned  = (addr[1:0] == 2'b00);

  for (genvar i = 0; i < NBANK; i++) begin : g_sel
    assign cfg_sel[i] = aligned && (word_idx == IDX_W'(i));
  end

  assign lock_hit = aligned && (word_idx == IDX_W'(LOCK_IDX));
  assign stat_hit = aligned && (word_idx == IDX_W'(STAT_IDX));

  always_comb begin
    // R8: at most one register is addressed at a time
    a_one_hit_r8 : assert ($onehot0({cfg_sel, lock_hit, stat_hit}));
  end
endmodule

// File: rtl/bank_cfg_lock.sv
module bank_cfg_lock (
  input  logic clk,
  input  logic rst_n,
  input  logic lock_wr,
  output logic lock_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)       lock_q <= 1'b0;
    else if (lock_wr) lock_q <= 1'b1;
  end

  p_lock_set_r4 : assert property (@(posedge clk) disable iff (!rst_n)
    lock_wr |=> lock_q);
  p_lock_sticky_r6 : assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q);
endmodule

// File: rtl/bank_cfg_word.sv
module bank_cfg_word
  import bank_cfg_pkg::*;
#(
  parameter logic [CFG_W-1:0] DEFAULT_CFG = 32'h7FFF_FFF0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_sel,
  input  logic             locked,
  input  logic [CFG_W-1:0] wdata,
  output logic [CFG_W-1:0] word_q,
  output logic             written_q
);
  logic accept;
  assign accept = wr_sel && !locked;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_q    <= cfg_sanitize(DEFAULT_CFG);
      written_q <= 1'b0;
    end else if (accept) begin
      word_q    <= cfg_sanitize(wdata);
      written_q <= 1'b1;
    end
  end

  p_rsvd_zero_r3 : assert property (@(posedge clk) disable iff (!rst_n)
    word_q[RSVD_BIT] == 1'b0);
  p_locked_hold_r5 : assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> $stable(word_q));
  p_status_rise_r7 : assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> written_q);
  p_status_sticky_r7 : assert property (@(posedge clk) disable iff (!rst_n)
    written_q |=> written_q);
endmodule

// File: rtl/bank_cfg_regs.sv
module bank_cfg_regs
  import bank_cfg_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int NBANK  = 4,
  parameter logic [CFG_W-1:0] DEFAULT_CFG = 32'h7FFF_FFF0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_wr,
  input  logic                   bus_rd,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic [CFG_W-1:0]       bus_wdata,
  output logic [CFG_W-1:0]       bus_rdata,
  output logic [NBANK*CFG_W-1:0] cfg_word_o,
  output logic [NBANK-1:0]       bank_narrow_o
);
  logic [NBANK-1:0] cfg_sel;
  logic             lock_hit;
  logic             stat_hit;
  logic             lock_q;
  logic [NBANK-1:0] written;
  logic [CFG_W-1:0] words [NBANK];
  logic [CFG_W-1:0] rd_word;
  logic             mapped;

  bank_cfg_decode #(.ADDR_W(ADDR_W), .NBANK(NBANK)) u_dec (
    .addr(bus_addr), .cfg_sel(cfg_sel), .lock_hit(lock_hit), .stat_hit(stat_hit)
  );

  bank_cfg_lock u_lock (
    .clk(clk), .rst_n(rst_n), .lock_wr(bus_wr && lock_hit), .lock_q(lock_q)
  );

  for (genvar i = 0; i < NBANK; i++) begin : g_bank
    bank_cfg_word #(.DEFAULT_CFG(DEFAULT_CFG)) u_word (
      .clk(clk), .rst_n(rst_n), .wr_sel(bus_wr && cfg_sel[i]), .locked(lock_q),
      .wdata(bus_wdata), .word_q(words[i]), .written_q(written[i])
    );
    assign cfg_word_o[i*CFG_W +: CFG_W] = words[i];
    assign bank_narrow_o[i] = cfg_is_narrow(words[i]);
  end

  assign mapped = (|cfg_sel) || lock_hit || stat_hit;

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < NBANK; i++)
      if (cfg_sel[i]) rd_word = words[i];
    if (stat_hit) rd_word = CFG_W'(written);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_word;
  end

  p_rdata_hold_r10 : assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));
  p_unmapped_zero_r8 : assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !mapped) |=> (bus_rdata == '0));
  p_lock_read_zero_r4 : assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && lock_hit) |=> (bus_rdata == '0));
endmodule

// File: tb/tb_bank_cfg_regs.sv
module tb_bank_cfg_regs;
  localparam logic [31:0] DEF = 32'h7FFF_FFF0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [127:0] cfg_word_o;
  logic [3:0]  bank_narrow_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  bank_cfg_regs #(.DEFAULT_CFG(DEF)) dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cfg_word_o(cfg_word_o), .bank_narrow_o(bank_narrow_o)
  );

  typedef struct packed {
    logic        rd;
    logic [7:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 8'h00, 32'h0, DEF,          4'd1},  // R1 default
    '{1'b1, 8'h14, 32'h0, 32'h0,        4'd1},  // R1 status clear
    '{1'b0, 8'h04, 32'h1234_5678, 32'h0, 4'd2},
    '{1'b1, 8'h04, 32'h0, 32'h1234_5678, 4'd2}, // R2 write lands
    '{1'b1, 8'h00, 32'h0, DEF,          4'd2},  // R2 neighbour untouched
    '{1'b0, 8'h08, 32'hFFFF_FFFF, 32'h0, 4'd3},
    '{1'b1, 8'h08, 32'h0, 32'h7FFF_FFFF, 4'd3}, // R3 bit 31 dropped
    '{1'b1, 8'h14, 32'h0, 32'h6,        4'd7},  // R7 bits 1,2
    '{1'b0, 8'h18, 32'hDEAD_BEEF, 32'h0, 4'd8},
    '{1'b1, 8'h18, 32'h0, 32'h0,        4'd8},  // R8 unmapped read
    '{1'b1, 8'h14, 32'h0, 32'h6,        4'd8},  // R8 no side effect
    '{1'b0, 8'h05, 32'hAAAA_AAAA, 32'h0, 4'd8},
    '{1'b1, 8'h04, 32'h0, 32'h1234_5678, 4'd8}, // R8 misaligned write ignored
    '{1'b1, 8'h05, 32'h0, 32'h0,        4'd8},  // R8 misaligned read
    '{1'b0, 8'h14, 32'hF, 32'h0,        4'd7},
    '{1'b1, 8'h14, 32'h0, 32'h6,        4'd7},  // R7 status not writable
    '{1'b0, 8'h0C, 32'h0000_0021, 32'h0, 4'd2},
    '{1'b1, 8'h0C, 32'h0, 32'h0000_0021, 4'd2},
    '{1'b1, 8'h10, 32'h0, 32'h0,        4'd4},  // R4 lock reads 0
    '{1'b0, 8'h10, 32'h0, 32'h0,        4'd4},  // lock with zero data
    '{1'b0, 8'h00, 32'h5555_5555, 32'h0, 4'd5},
    '{1'b1, 8'h00, 32'h0, DEF,          4'd5},  // R5 locked write dropped
    '{1'b1, 8'h14, 32'h0, 32'hE,        4'd7},  // R7 rejected write no bit
    '{1'b1, 8'h10, 32'h0, 32'h0,        4'd4}   // R4 lock still reads 0
  };

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    @(negedge clk); bus_rd = 0; d = bus_rdata;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: exports at reset
    check("R1", cfg_word_o, {4{DEF}});
    check("R9", {124'h0, bank_narrow_o}, 128'hF);

    for (int k = 0; k < NV; k++) begin
      if (VECS[k].rd) begin
        rd(VECS[k].addr, r);
        check($sformatf("R%0d", VECS[k].req), {96'h0, r}, {96'h0, VECS[k].exp});
      end else begin
        wr(VECS[k].addr, VECS[k].data);
      end
    end

    // R9: exports follow stored words; bank3 0x21 has width bit 4 clear
    check("R9", cfg_word_o, {32'h0000_0021, 32'h7FFF_FFFF, 32'h1234_5678, DEF});
    check("R9", {124'h0, bank_narrow_o}, {124'h0, 4'b0111});

    // R6: rewrites of lock and writes elsewhere cannot unlock
    wr(8'h10, 32'hFFFF_FFFF);
    wr(8'h14, 32'h0);
    wr(8'h0C, 32'h0);
    rd(8'h0C, r);
    check("R6", {96'h0, r}, {96'h0, 32'h0000_0021});

    // R10: rdata holds while bus_rd is low
    @(negedge clk); bus_addr = 8'h04;
    repeat (3) @(negedge clk);
    check("R10", {96'h0, bus_rdata}, {96'h0, 32'h0000_0021});

    // R1/R6: reset reopens the block
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    check("R1", cfg_word_o, {4{DEF}});
    check("R1", {96'h0, bus_rdata}, 128'h0);
    wr(8'h00, 32'h0000_0003);
    rd(8'h00, r);
    check("R6", {96'h0, r}, {96'h0, 32'h0000_0003});

    // R10: same-cycle write and read see the old value
    @(negedge clk); bus_wr = 1; bus_rd = 1; bus_addr = 8'h00; bus_wdata = 32'h0000_0044;
    @(negedge clk); bus_wr = 0; bus_rd = 0;
    check("R10", {96'h0, bus_rdata}, {96'h0, 32'h0000_0003});
    rd(8'h00, r);
    check("R10", {96'h0, r}, {96'h0, 32'h0000_0044});

    // R7: status after reset shows only bank 0
    rd(8'h14, r);
    check("R7", {96'h0, r}, 128'h1);

    finish_run();
  end
endmodule